// File: doc/BRIEF.md
# First/Next Error Logging Unit

This unit records bus error events for later inspection by software. Each error arrives as a single-cycle pulse with two tags. The first tag is a class, fatal or non-fatal. The second is a type: master abort, target abort, address parity or data parity. With every pulse the unit also receives the live bus values and the context values of the original request. The live values are address, data, byte enables and header. The context values are the request address and data.

The first error of each class sets a bit in the first-error status register. It also loads one shared set of log registers. Which values go into the log depends on the error type. A fatal error may replace a log written by a non-fatal one. A non-fatal error can never replace a fatal log. Later errors set only a bit in the next-error status register. Every accepted error raises a one-cycle message request.

Software reads both status registers and the log through a small register port. It clears status bits by writing ones to them. Once the first-error register is fully clear, the next error is treated as a new first error.

Top module: `err_log_unit`

## Requirements
- R1: After a synchronous active-low reset, both status registers, all log registers and `msg_req` are zero.
- R2: Status bit encoding is the same in both status registers. Bits 3:0 are non-fatal and bits 7:4 are fatal. Within each group the bit index equals the type code: master abort 0, target abort 1, address parity 2, data parity 3. A non-fatal error that arrives while the first-error register is entirely zero sets its non-fatal bit there and loads the log.
- R3: A fatal error that arrives while no fatal bit is set in the first-error register does three things. It sets its fatal bit there, reloads the log even if a non-fatal log is held, and leaves any non-fatal bit as it was.
- R4: A non-fatal error that arrives while the first-error register is non-zero sets its bit in the next-error register. It leaves the log unchanged.
- R5: A fatal error that arrives while a fatal bit is already set in the first-error register sets its bit in the next-error register. It leaves the log unchanged.
- R6: For master abort and target abort, the log takes the context address and the context data. The logged byte enables and header are zero.
- R7: For address parity, the log takes the live address, data, byte enables and header.
- R8: For data parity, the log takes the context address, the live data and the live byte enables. The logged header is zero.
- R9: Register map for reads: 0 is first-error status, 1 is next-error status, 2 is log address, 3 is log data, 4 is log byte enables and 5 is log header. Values are zero-extended, and any other address reads zero. A write to address 0 or 1 clears every status bit written as 1 and leaves the other bits alone. Writes to any other address have no effect.
- R10: When an error sets a status bit in the same cycle that software clears that bit, the bit ends up set.
- R11: After the first-error register has been fully cleared, the next error of either class is logged as a first error and reloads the log. The next-error register is not affected.
- R12: `msg_req` is high for exactly the one cycle after each accepted error pulse, whether the error was logged as a first or a next error. It is low otherwise.
- R13: The first-error register never holds more than one fatal bit or more than one non-fatal bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | One-cycle error event pulse |
| err_fatal | input | 1 | Class of the event: 1 fatal, 0 non-fatal |
| err_kind | input | 2 | Type code: 0 master abort, 1 target abort, 2 address parity, 3 data parity |
| live_addr | input | ADDR_W | Address currently on the bus |
| live_data | input | DATA_W | Data currently on the bus |
| live_be | input | BE_W | Byte enables currently on the bus |
| live_hdr | input | HDR_W | Header currently on the bus |
| ctx_addr | input | ADDR_W | Address of the original request |
| ctx_data | input | DATA_W | Data of the original request |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data (ones clear status bits) |
| reg_rdata | output | REG_W | Read data of the selected register |
| msg_req | output | 1 | Error message request pulse |

## Verification
The bench builds the unit with 32-bit address, data and register widths. It sets the byte-enable width to 8 and the header width to 24. The narrower fields make the zero-extension on the register port observable, and the wider byte enables let the live and zeroed byte-enable cases be told apart clearly. With these values, each capture rule can be separated by reading back the four log fields alone. The rules covered are context-only, live-only, and live data with the context address.

// File: rtl/err_log_pkg.sv
// Package err_log_pkg
// Shared encodings for the error logging unit: type codes, the layout of
// the status registers, the log source selection and the register map.
// Assumes four error types and two classes.
package err_log_pkg;

    typedef enum logic [1:0] {
        KIND_MA  = 2'd0,
        KIND_TA  = 2'd1,
        KIND_APE = 2'd2,
        KIND_DPE = 2'd3
    } err_kind_e;

    localparam int NUM_KINDS = 4;
    localparam int STAT_W    = 2 * NUM_KINDS;
    localparam int RADDR_W   = 3;

    typedef enum logic [1:0] {
        SRC_CTX   = 2'd0,
        SRC_LIVE  = 2'd1,
        SRC_MIXED = 2'd2
    } log_src_e;

    localparam logic [RADDR_W-1:0] RA_FIRST = 3'd0;
    localparam logic [RADDR_W-1:0] RA_NEXT  = 3'd1;
    localparam logic [RADDR_W-1:0] RA_LADDR = 3'd2;
    localparam logic [RADDR_W-1:0] RA_LDATA = 3'd3;
    localparam logic [RADDR_W-1:0] RA_LBE   = 3'd4;
    localparam logic [RADDR_W-1:0] RA_LHDR  = 3'd5;

    // Map an error type to the set of values its log entry keeps.
    function automatic log_src_e src_of(input err_kind_e k);
        case (k)
            KIND_APE: return SRC_LIVE;
            KIND_DPE: return SRC_MIXED;
            default:  return SRC_CTX;
        endcase
    endfunction

endpackage

// File: rtl/err_route.sv
// Module err_route
// Decides where an incoming error event lands. It either becomes a first
// error (status bit in the first-error register plus a log load) or a next
// error (status bit in the next-error register only).
// Assumes at most one event per cycle; purely combinational.
module err_route
    import err_log_pkg::*;
(
    input  logic              err_valid,
    input  logic              err_fatal,
    input  err_kind_e         err_kind,
    input  logic [STAT_W-1:0] first_q,
    output logic [STAT_W-1:0] first_set,
    output logic [STAT_W-1:0] next_set,
    output logic              log_load
);

    logic [STAT_W-1:0] bit_vec;
    logic              fatal_free;
    logic              all_clear;
    logic              take_first;

    // Build the one-hot status bit for this class and type.
    always_comb begin
        bit_vec = '0;
        bit_vec[(err_fatal ? NUM_KINDS : 0) + int'(err_kind)] = 1'b1;
    end

    // Choose between first-error and next-error handling.
    always_comb begin
        fatal_free = (first_q[STAT_W-1:NUM_KINDS] == '0);
        all_clear  = (first_q == '0);
        take_first = err_valid && (err_fatal ? fatal_free : all_clear);
        first_set  = take_first ? bit_vec : '0;
        next_set   = (err_valid && !take_first) ? bit_vec : '0;
        log_load   = take_first;
    end

endmodule

// File: rtl/err_capture.sv
// Module err_capture
// Holds the shared log registers. On a load it selects context values,
// live values, or live data with the context address, according to the
// error type. Fields with no source for that type are written as zero.
// Assumes load is asserted only for errors accepted as first errors.
module err_capture
    import err_log_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int HDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  err_kind_e         kind,
    input  logic [ADDR_W-1:0] live_addr,
    input  logic [DATA_W-1:0] live_data,
    input  logic [BE_W-1:0]   live_be,
    input  logic [HDR_W-1:0]  live_hdr,
    input  logic [ADDR_W-1:0] ctx_addr,
    input  logic [DATA_W-1:0] ctx_data,
    output logic [ADDR_W-1:0] log_addr,
    output logic [DATA_W-1:0] log_data,
    output logic [BE_W-1:0]   log_be,
    output logic [HDR_W-1:0]  log_hdr
);

    logic [ADDR_W-1:0] nxt_addr;
    logic [DATA_W-1:0] nxt_data;
    logic [BE_W-1:0]   nxt_be;
    logic [HDR_W-1:0]  nxt_hdr;

    // Select the capture values for the current error type.
    always_comb begin
        case (src_of(kind))
            SRC_LIVE: begin
                nxt_addr = live_addr;
                nxt_data = live_data;
                nxt_be   = live_be;
                nxt_hdr  = live_hdr;
            end
            SRC_MIXED: begin
                nxt_addr = ctx_addr;
                nxt_data = live_data;
                nxt_be   = live_be;
                nxt_hdr  = '0;
            end
            default: begin
                nxt_addr = ctx_addr;
                nxt_data = ctx_data;
                nxt_be   = '0;
                nxt_hdr  = '0;
            end
        endcase
    end

    // Load the log registers on an accepted first error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_addr <= '0;
            log_data <= '0;
            log_be   <= '0;
            log_hdr  <= '0;
        end else if (load) begin
            log_addr <= nxt_addr;
            log_data <= nxt_data;
            log_be   <= nxt_be;
            log_hdr  <= nxt_hdr;
        end
    end

endmodule

// File: rtl/err_status.sv
// Module err_status
// One write-one-to-clear status register. Bits set by hardware take
// precedence over a software clear arriving in the same cycle.
// Assumes set and clear vectors are already qualified by their sources.
module err_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);

    // Apply clears first, then sets, so a new event survives a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_vec) | set_vec;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q & $past(set_vec)) == $past(set_vec))); // R10

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q & $past(clr_vec & ~set_vec)) == '0)); // R9

endmodule

// File: rtl/err_log_unit.sv
// Module err_log_unit
// Top of the error logging unit. It routes error events into first-error
// and next-error status, captures the shared log, provides the register
// read/write port and raises a message request per accepted error.
// Assumes one error event per cycle and log field widths not above REG_W.
module err_log_unit
    import err_log_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int HDR_W  = 32,
    parameter int REG_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_valid,
    input  logic               err_fatal,
    input  logic [1:0]         err_kind,
    input  logic [ADDR_W-1:0]  live_addr,
    input  logic [DATA_W-1:0]  live_data,
    input  logic [BE_W-1:0]    live_be,
    input  logic [HDR_W-1:0]   live_hdr,
    input  logic [ADDR_W-1:0]  ctx_addr,
    input  logic [DATA_W-1:0]  ctx_data,
    input  logic [2:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               msg_req
);

    localparam int NREG = 2;

    logic [STAT_W-1:0] set_arr [NREG];
    logic [STAT_W-1:0] clr_arr [NREG];
    logic [STAT_W-1:0] stat_q  [NREG];
    logic              log_load;
    logic [ADDR_W-1:0] log_addr;
    logic [DATA_W-1:0] log_data;
    logic [BE_W-1:0]   log_be;
    logic [HDR_W-1:0]  log_hdr;
    logic              msg_q;

    err_route u_route (
        .err_valid (err_valid),
        .err_fatal (err_fatal),
        .err_kind  (err_kind_e'(err_kind)),
        .first_q   (stat_q[0]),
        .first_set (set_arr[0]),
        .next_set  (set_arr[1]),
        .log_load  (log_load)
    );

    err_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .HDR_W  (HDR_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (log_load),
        .kind      (err_kind_e'(err_kind)),
        .live_addr (live_addr),
        .live_data (live_data),
        .live_be   (live_be),
        .live_hdr  (live_hdr),
        .ctx_addr  (ctx_addr),
        .ctx_data  (ctx_data),
        .log_addr  (log_addr),
        .log_data  (log_data),
        .log_be    (log_be),
        .log_hdr   (log_hdr)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_stat
        // Derive the clear mask for this status register from the write port.
        always_comb begin
            clr_arr[g] = (reg_wr && (reg_addr == RADDR_W'(g)))
                       ? reg_wdata[STAT_W-1:0] : '0;
        end

        err_status #(.W(STAT_W)) u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_arr[g]),
            .clr_vec (clr_arr[g]),
            .q       (stat_q[g])
        );
    end

    // Zero-extend the selected register onto the read bus.
    always_comb begin
        case (reg_addr)
            RA_FIRST: reg_rdata = REG_W'(stat_q[0]);
            RA_NEXT:  reg_rdata = REG_W'(stat_q[1]);
            RA_LADDR: reg_rdata = REG_W'(log_addr);
            RA_LDATA: reg_rdata = REG_W'(log_data);
            RA_LBE:   reg_rdata = REG_W'(log_be);
            RA_LHDR:  reg_rdata = REG_W'(log_hdr);
            default:  reg_rdata = '0;
        endcase
    end

    // Raise one message request per accepted error event.
    always_ff @(posedge clk) begin
        if (!rst_n) msg_q <= 1'b0;
        else        msg_q <= err_valid;
    end

    assign msg_req = msg_q;

    AST_FIRST_ONE_PER_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_q[0][NUM_KINDS-1:0]) && $onehot0(stat_q[0][STAT_W-1:NUM_KINDS])); // R13

    AST_NF_KEEPS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !err_fatal && (stat_q[0] != '0))
        |=> ($stable(log_addr) && $stable(log_data) && $stable(log_be) && $stable(log_hdr))); // R4

    AST_FATAL_KEEPS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_fatal && (stat_q[0][STAT_W-1:NUM_KINDS] != '0))
        |=> ($stable(log_addr) && $stable(log_data) && $stable(log_be) && $stable(log_hdr))); // R5

    AST_FATAL_TAKES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_fatal && (stat_q[0][STAT_W-1:NUM_KINDS] == '0))
        |=> stat_q[0][NUM_KINDS + int'($past(err_kind))]); // R3

    AST_MSG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> msg_req); // R12

    AST_MSG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> !msg_req); // R12

endmodule

// File: tb/err_log_unit_test.sv
module err_log_unit_test;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = 8;
    localparam int HDR_W  = 24;
    localparam int REG_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              err_valid = 1'b0;
    logic              err_fatal = 1'b0;
    logic [1:0]        err_kind = 2'd0;
    logic [ADDR_W-1:0] live_addr = '0;
    logic [DATA_W-1:0] live_data = '0;
    logic [BE_W-1:0]   live_be = '0;
    logic [HDR_W-1:0]  live_hdr = '0;
    logic [ADDR_W-1:0] ctx_addr = '0;
    logic [DATA_W-1:0] ctx_data = '0;
    logic [2:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              msg_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    err_log_unit #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .BE_W (BE_W),
        .HDR_W (HDR_W), .REG_W (REG_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .err_valid (err_valid), .err_fatal (err_fatal),
        .err_kind (err_kind), .live_addr (live_addr), .live_data (live_data),
        .live_be (live_be), .live_hdr (live_hdr), .ctx_addr (ctx_addr),
        .ctx_data (ctx_data), .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .msg_req (msg_req)
    );

    // Error sequence applied with no clears: {fatal, kind, exp_first, exp_next, log_idx}
    localparam int NV = 6;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 2'd1, 8'h02, 8'h00, 3'd0},  // R2 first non-fatal TA
        {1'b0, 2'd0, 8'h02, 8'h01, 3'd0},  // R4 non-fatal MA goes to next
        {1'b1, 2'd2, 8'h42, 8'h01, 3'd2},  // R3 fatal APE replaces log
        {1'b0, 2'd3, 8'h42, 8'h09, 3'd2},  // R4 non-fatal DPE to next
        {1'b1, 2'd0, 8'h42, 8'h19, 3'd2},  // R5 fatal MA to next
        {1'b1, 2'd3, 8'h42, 8'h99, 3'd2}   // R5 fatal DPE to next
    };
    logic [1:0] kind_of_idx [16];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // One cycle of stimulus starting and ending at a falling edge.
    task automatic step(input logic ev, input logic fat, input logic [1:0] k, input int idx,
                        input logic wr, input logic [2:0] wa, input logic [31:0] wd);
        err_valid = ev;
        err_fatal = fat;
        err_kind  = k;
        live_addr = {8'hA0, 24'(idx)};
        live_data = {8'hB0, 24'(idx)};
        live_be   = 8'h5A ^ 8'(idx);
        live_hdr  = {8'hE0, 16'(idx)};
        ctx_addr  = {8'hC0, 24'(idx)};
        ctx_data  = {8'hD0, 24'(idx)};
        reg_wr    = wr;
        reg_addr  = wa;
        reg_wdata = wd;
        if (ev) kind_of_idx[idx] = k;
        @(posedge clk);
        @(negedge clk);
        err_valid = 1'b0;
        reg_wr    = 1'b0;
    endtask

    // Compare status and log against values derived from the capture rules.
    task automatic check_regs(input string req, input logic [7:0] efe, input logic [7:0] ene,
                              input int idx);
        logic [31:0] v, ea, ed, eb, eh;
        logic [1:0] k;
        k = kind_of_idx[idx];
        case (k)
            2'd2:    begin ea = {8'hA0, 24'(idx)}; ed = {8'hB0, 24'(idx)};
                           eb = 32'(8'h5A ^ 8'(idx)); eh = {8'h00, 8'hE0, 16'(idx)}; end
            2'd3:    begin ea = {8'hC0, 24'(idx)}; ed = {8'hB0, 24'(idx)};
                           eb = 32'(8'h5A ^ 8'(idx)); eh = '0; end
            default: begin ea = {8'hC0, 24'(idx)}; ed = {8'hD0, 24'(idx)};
                           eb = '0; eh = '0; end
        endcase
        rd(3'd0, v); chk({req, " first"}, v, 32'(efe));
        rd(3'd1, v); chk({req, " next"}, v, 32'(ene));
        rd(3'd2, v); chk({req, " log_addr"}, v, ea);
        rd(3'd3, v); chk({req, " log_data"}, v, ed);
        rd(3'd4, v); chk({req, " log_be"}, v, eb);
        rd(3'd5, v); chk({req, " log_hdr"}, v, eh);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        for (int i = 0; i < 16; i++) kind_of_idx[i] = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every register and on msg_req
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 msg_req", 32'(msg_req), 32'h0);

        // Table walk: each event is followed by a quiet cycle
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][21], VEC[i][20:19], i, 1'b0, 3'd0, 32'h0);
            chk("R12 msg_req after event", 32'(msg_req), 32'h1);
            check_regs("R2 R3 R4 R5 R6 R7 table", VEC[i][18:11], VEC[i][10:3], int'(VEC[i][2:0]));
            step(1'b0, 1'b0, 2'd0, 0, 1'b0, 3'd0, 32'h0);
            chk("R12 msg_req quiet", 32'(msg_req), 32'h0);
        end

        // R9: writes to a log address and a zero write leave everything alone
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 3'd2, 32'hFFFF_FFFF);
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 3'd0, 32'h0);
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 3'd6, 32'hFFFF_FFFF);
        check_regs("R9 no-effect writes", 8'h42, 8'h99, 2);
        rd(3'd6, v); chk("R9 unmapped reads zero", v, 32'h0);

        // R9: clear the non-fatal first bit only
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 3'd0, 32'h02);
        check_regs("R9 clear first nf", 8'h40, 8'h99, 2);

        // R4: non-fatal while only a fatal first bit is set
        step(1'b1, 1'b0, 2'd1, 7, 1'b0, 3'd0, 32'h0);
        check_regs("R4 nf behind fatal", 8'h40, 8'h9B, 2);

        // R9: clear the whole next register
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 3'd1, 32'hFF);
        check_regs("R9 clear next", 8'h40, 8'h00, 2);

        // R10: next bit set and cleared in the same cycle stays set
        step(1'b1, 1'b0, 2'd0, 8, 1'b1, 3'd1, 32'h01);
        check_regs("R10 set wins next", 8'h40, 8'h01, 2);

        // R11 R8: clear first, then a fatal DPE becomes the new first error
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 3'd0, 32'h40);
        step(1'b1, 1'b1, 2'd3, 9, 1'b0, 3'd0, 32'h0);
        check_regs("R11 R8 fatal dpe reloads", 8'h80, 8'h01, 9);

        // R11 R6: clear first, non-fatal MA logs context with zero be and header
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 3'd0, 32'h80);
        step(1'b1, 1'b0, 2'd0, 10, 1'b0, 3'd0, 32'h0);
        check_regs("R11 R6 nf ma reloads", 8'h01, 8'h01, 10);

        // R3 R10 R13: fatal TA with a same-cycle clear of the non-fatal bit
        step(1'b1, 1'b1, 2'd1, 11, 1'b1, 3'd0, 32'h01);
        check_regs("R3 R10 R13 fatal ta with clear", 8'h20, 8'h01, 11);

        // R7: fresh first error of address-parity type keeps all live fields
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 3'd0, 32'hFF);
        step(1'b1, 1'b0, 2'd2, 12, 1'b0, 3'd0, 32'h0);
        check_regs("R7 nf ape live", 8'h04, 8'h01, 12);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule